// File: doc/BRIEF.md
# LBP Boosted-Classifier Stage with Shared Two-Source Input

This block is one strong-classifier stage of a boosted face-detection cascade that works on local-binary-pattern (LBP) codes. A candidate window arrives as a bus of 8-bit LBP codes, one per feature location. Each code addresses that feature's own confidence table. The signed confidences read from all tables are added in a fully registered adder tree, and the total is compared with a stage threshold. The stage accepts a new candidate on every clock and gives one decision per clock once the pipeline has filled.

Two request sources share the stage, for example a pair of pyramid levels whose valid pixels never coincide, or two results from earlier stages. Source B stands for the lower-resolution image. When both sources request in the same cycle, B is served and A's request is dropped, and a collision flag pulses for that cycle. Each result carries the pass/fail decision, the summed confidence, the tag of the source that was served and the window coordinate that came with the request. Table contents and the threshold are loaded through a plain write port. Reset clears both.

Top module: `lbp_cascade_stage`

## Requirements
- R1: After reset, res_valid, res_pass and collision are 0, every table entry reads as 0 and the threshold is 0, so a candidate then sums to 0 and fails.
- R2: Feature f takes its code from bits [8f+7:8f] of the selected code bus, and its confidence is the entry of table f at that code.
- R3: res_sum is the signed sum of all feature confidences (8-bit two's complement each), in an 11-bit signed result that cannot overflow: 8 entries of +127 give +1016 and 8 entries of -128 give -1024.
- R4: res_pass is 1 exactly when res_sum is strictly greater than the signed threshold. A sum equal to the threshold fails.
- R5: A request presented in cycle n produces its result with res_valid high in cycle n+6 for the 8-feature default, and back-to-back requests give back-to-back results.
- R6: A request from A alone is served with res_src = 0, and a request from B alone is served with res_src = 1.
- R7: When A and B request in the same cycle, only B's request is served (res_src = 1), A's is dropped, and collision is high for exactly the following cycle.
- R8: res_coord equals the coordinate that came with the served request.
- R9: A table write (feature index, address, data) or a threshold write takes effect for requests presented in any later cycle.
- R10: With no request in cycle n, res_valid and res_pass are 0 in cycle n+6.
- R11: A reset in the middle of operation discards all requests in flight and returns the tables and the threshold to their reset contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tbl_we | input | 1 | Write one table entry |
| cfg_feat | input | 3 | Feature (table) index for the write |
| cfg_addr | input | 8 | Table address (LBP code) for the write |
| cfg_data | input | 8 | Signed confidence to write |
| cfg_thr_we | input | 1 | Write the threshold |
| cfg_thr | input | 11 | Signed threshold value |
| a_valid | input | 1 | Request from source A (higher resolution) |
| a_codes | input | 64 | LBP codes of A's window, feature f at [8f+7:8f] |
| a_coord | input | 16 | Window coordinate of A's request |
| b_valid | input | 1 | Request from source B (lower resolution, wins) |
| b_codes | input | 64 | LBP codes of B's window |
| b_coord | input | 16 | Window coordinate of B's request |
| res_valid | output | 1 | Result valid |
| res_pass | output | 1 | Candidate passes the stage |
| res_sum | output | 11 | Signed summed confidence |
| res_src | output | 1 | Source served: 0 = A, 1 = B |
| res_coord | output | 16 | Coordinate of the served request |
| collision | output | 1 | Both sources requested in the previous cycle |

## Verification
A wrong table entry or a wrong address slice shows as a wrong res_sum six cycles after the first request that touches it. Random request streams over fully loaded tables make this likely within a few hundred requests. A misaligned sideband delay line shows at once as a res_src or res_coord that belongs to a neighbouring request, or as res_valid one cycle off, on the first result after a gap. A stale threshold, a write flag that survives reset or a wrong priority shows at the first compare that lands on the threshold boundary, the first candidate after reset, or the first collision.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  // Which request source a result belongs to
  typedef enum logic {
    SRC_HI_RES = 1'b0,
    SRC_LO_RES = 1'b1
  } src_e;

  // Registered adder-tree depth; at least one level
  function automatic int tree_levels(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lcs_arbiter.sv
// Fixed-priority pick between two request sources, registered.
module lcs_arbiter #(
  parameter int CODES_W = 64,
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_valid,
  input  logic [CODES_W-1:0] a_codes,
  input  logic [COORD_W-1:0] a_coord,
  input  logic               b_valid,
  input  logic [CODES_W-1:0] b_codes,
  input  logic [COORD_W-1:0] b_coord,
  output logic               sel_valid,
  output logic               sel_src,
  output logic [CODES_W-1:0] sel_codes,
  output logic [COORD_W-1:0] sel_coord,
  output logic               collision
);
  import lcs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_src   <= SRC_HI_RES;
      sel_codes <= '0;
      sel_coord <= '0;
      collision <= 1'b0;
    end else begin
      sel_valid <= a_valid | b_valid;
      collision <= a_valid & b_valid;
      // lower-resolution source has priority
      if (b_valid) begin
        sel_src   <= SRC_LO_RES;
        sel_codes <= b_codes;
        sel_coord <= b_coord;
      end else begin
        sel_src   <= SRC_HI_RES;
        sel_codes <= a_codes;
        sel_coord <= a_coord;
      end
    end
  end

endmodule

// File: rtl/lcs_conf_table.sv
// One weak classifier: synchronous-read confidence table.
// The data array has no reset so it maps to block RAM; a per-entry
// written flag makes unwritten entries read as zero after reset.
module lcs_conf_table #(
  parameter int CODE_W = 8,
  parameter int CONF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [CONF_W-1:0] wdata,
  input  logic [CODE_W-1:0] raddr,
  output logic [CONF_W-1:0] rdata
);
  localparam int DEPTH = 1 << CODE_W;

  logic [CONF_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wflag;
  logic [CONF_W-1:0] mem_q;
  logic              flag_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wflag  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (we) wflag[waddr] <= 1'b1;
      flag_q <= wflag[raddr];
    end
  end

  assign rdata = flag_q ? mem_q : '0;

endmodule

// File: rtl/lcs_adder_tree.sv
// Pipelined signed adder tree, one register per level.
module lcs_adder_tree #(
  parameter int N_IN = 8,
  parameter int IN_W = 8,
  parameter int OUT_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN*IN_W-1:0]    leaves_in,
  output logic signed [OUT_W-1:0] total
);
  localparam int LVLS  = lcs_pkg::tree_levels(N_IN);
  localparam int P2    = 1 << LVLS;
  localparam int NODES = P2 - 1;

  logic signed [OUT_W-1:0] leaf [P2];
  logic signed [OUT_W-1:0] tr   [NODES];
  logic signed [OUT_W-1:0] allv [2*P2-1];

  for (genvar j = 0; j < P2; j++) begin : g_leaf
    if (j < N_IN) begin : g_real
      assign leaf[j] = {{(OUT_W-IN_W){leaves_in[j*IN_W+IN_W-1]}},
                        leaves_in[j*IN_W +: IN_W]};
    end else begin : g_pad
      assign leaf[j] = '0;
    end
  end

  // heap layout: node i has children 2i+1 and 2i+2; leaves follow the nodes
  always_comb begin
    for (int i = 0; i < NODES; i++) allv[i] = tr[i];
    for (int j = 0; j < P2; j++) allv[NODES+j] = leaf[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NODES; i++) tr[i] <= '0;
    end else begin
      for (int i = 0; i < NODES; i++) tr[i] <= allv[2*i+1] + allv[2*i+2];
    end
  end

  assign total = tr[0];

endmodule

// File: rtl/lbp_cascade_stage.sv
// One boosted-cascade stage shared by two request sources.
module lbp_cascade_stage #(
  parameter int N_FEAT  = 8,
  parameter int CODE_W  = 8,
  parameter int CONF_W  = 8,
  parameter int COORD_W = 16,
  localparam int LVLS   = lcs_pkg::tree_levels(N_FEAT),
  localparam int SUM_W  = CONF_W + LVLS,
  localparam int FIDX_W = (N_FEAT > 1) ? $clog2(N_FEAT) : 1,
  localparam int CODES_W = N_FEAT * CODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_tbl_we,
  input  logic [FIDX_W-1:0]       cfg_feat,
  input  logic [CODE_W-1:0]       cfg_addr,
  input  logic [CONF_W-1:0]       cfg_data,
  input  logic                    cfg_thr_we,
  input  logic signed [SUM_W-1:0] cfg_thr,
  input  logic                    a_valid,
  input  logic [CODES_W-1:0]      a_codes,
  input  logic [COORD_W-1:0]      a_coord,
  input  logic                    b_valid,
  input  logic [CODES_W-1:0]      b_codes,
  input  logic [COORD_W-1:0]      b_coord,
  output logic                    res_valid,
  output logic                    res_pass,
  output logic signed [SUM_W-1:0] res_sum,
  output logic                    res_src,
  output logic [COORD_W-1:0]      res_coord,
  output logic                    collision
);
  // sideband waits for the table read plus every tree level
  localparam int DLY  = 1 + LVLS;
  localparam int SB_W = 2 + COORD_W;

  logic                    sel_valid;
  logic                    sel_src;
  logic [CODES_W-1:0]      sel_codes;
  logic [COORD_W-1:0]      sel_coord;
  logic [N_FEAT*CONF_W-1:0] conf_bus;
  logic signed [SUM_W-1:0] tree_sum;
  logic signed [SUM_W-1:0] thr_q;
  logic [SB_W-1:0]         sband [DLY];
  logic                    d_valid;
  logic                    d_src;
  logic [COORD_W-1:0]      d_coord;

  lcs_arbiter #(
    .CODES_W(CODES_W),
    .COORD_W(COORD_W)
  ) arb_i (
    .clk      (clk),
    .rst      (rst),
    .a_valid  (a_valid),
    .a_codes  (a_codes),
    .a_coord  (a_coord),
    .b_valid  (b_valid),
    .b_codes  (b_codes),
    .b_coord  (b_coord),
    .sel_valid(sel_valid),
    .sel_src  (sel_src),
    .sel_codes(sel_codes),
    .sel_coord(sel_coord),
    .collision(collision)
  );

  for (genvar f = 0; f < N_FEAT; f++) begin : g_feat
    logic feat_we;
    assign feat_we = cfg_tbl_we && (cfg_feat == FIDX_W'(f));

    lcs_conf_table #(
      .CODE_W(CODE_W),
      .CONF_W(CONF_W)
    ) tbl_i (
      .clk  (clk),
      .rst  (rst),
      .we   (feat_we),
      .waddr(cfg_addr),
      .wdata(cfg_data),
      .raddr(sel_codes[f*CODE_W +: CODE_W]),
      .rdata(conf_bus[f*CONF_W +: CONF_W])
    );
  end

  lcs_adder_tree #(
    .N_IN (N_FEAT),
    .IN_W (CONF_W),
    .OUT_W(SUM_W)
  ) tree_i (
    .clk      (clk),
    .rst      (rst),
    .leaves_in(conf_bus),
    .total    (tree_sum)
  );

  always_ff @(posedge clk) begin
    if (rst)             thr_q <= '0;
    else if (cfg_thr_we) thr_q <= cfg_thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DLY; k++) sband[k] <= '0;
    end else begin
      sband[0] <= {sel_valid, sel_src, sel_coord};
      for (int k = 1; k < DLY; k++) sband[k] <= sband[k-1];
    end
  end

  assign {d_valid, d_src, d_coord} = sband[DLY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_sum   <= '0;
      res_src   <= 1'b0;
      res_coord <= '0;
    end else begin
      res_valid <= d_valid;
      res_pass  <= d_valid && (tree_sum > thr_q);
      res_sum   <= tree_sum;
      res_src   <= d_src;
      res_coord <= d_coord;
    end
  end

endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int N_FEAT = 8,
  parameter int CONF_W = 8,
  parameter int SUM_W  = 11
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    a_valid,
  input logic                    b_valid,
  input logic                    cfg_thr_we,
  input logic signed [SUM_W-1:0] cfg_thr,
  input logic                    res_valid,
  input logic                    res_pass,
  input logic signed [SUM_W-1:0] res_sum,
  input logic                    res_src,
  input logic                    collision
);
  localparam int LAT = 2 + lcs_pkg::tree_levels(N_FEAT) + 1;
  localparam int HI  = N_FEAT * ((1 << (CONF_W-1)) - 1);
  localparam int LO  = -N_FEAT * (1 << (CONF_W-1));

  logic [LAT-1:0]          vpipe;
  logic [LAT-1:0]          spipe;
  logic signed [SUM_W-1:0] thr_shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe      <= '0;
      spipe      <= '0;
      thr_shadow <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], a_valid | b_valid};
      spipe <= {spipe[LAT-2:0], b_valid};
      if (cfg_thr_we) thr_shadow <= cfg_thr;
    end
  end

  // R5 R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == vpipe[LAT-1]);

  // R6 R7
  src_pick_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_src == spipe[LAT-1]));

  // R7
  collision_cause_chk: assert property (@(posedge clk) disable iff (rst)
    collision |-> $past(a_valid && b_valid));

  // R7
  collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && b_valid) |=> collision);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_sum) <= HI && int'(res_sum) >= LO));

  // R4
  threshold_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_pass == (res_sum > $past(thr_shadow))));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_pass);

endmodule

bind lbp_cascade_stage lcs_checker #(
  .N_FEAT(N_FEAT),
  .CONF_W(CONF_W),
  .SUM_W (SUM_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .a_valid   (a_valid),
  .b_valid   (b_valid),
  .cfg_thr_we(cfg_thr_we),
  .cfg_thr   (cfg_thr),
  .res_valid (res_valid),
  .res_pass  (res_pass),
  .res_sum   (res_sum),
  .res_src   (res_src),
  .collision (collision)
);

// File: tb/lbp_cascade_stage_tb_top.sv
module lbp_cascade_stage_tb_top;
  localparam int NF  = 8;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_tbl_we = 1'b0;
  logic [2:0]  cfg_feat = '0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        cfg_thr_we = 1'b0;
  logic signed [10:0] cfg_thr = '0;
  logic        a_valid = 1'b0;
  logic [63:0] a_codes = '0;
  logic [15:0] a_coord = '0;
  logic        b_valid = 1'b0;
  logic [63:0] b_codes = '0;
  logic [15:0] b_coord = '0;
  logic        res_valid;
  logic        res_pass;
  logic signed [10:0] res_sum;
  logic        res_src;
  logic [15:0] res_coord;
  logic        collision;

  always #4 clk = ~clk;

  lbp_cascade_stage dut_i (
    .clk(clk), .rst(rst),
    .cfg_tbl_we(cfg_tbl_we), .cfg_feat(cfg_feat), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
    .a_valid(a_valid), .a_codes(a_codes), .a_coord(a_coord),
    .b_valid(b_valid), .b_codes(b_codes), .b_coord(b_coord),
    .res_valid(res_valid), .res_pass(res_pass), .res_sum(res_sum),
    .res_src(res_src), .res_coord(res_coord), .collision(collision)
  );

  typedef struct {
    bit v;
    bit src;
    int sum;
    bit pass;
    int coord;
  } exp_t;

  exp_t q[$];
  int   tbl [NF][256];
  int   thr_m;
  bit   coll_prev;
  int   n_cmp;
  int   n_bad;
  bit   finished;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic compare_outputs();
    exp_t e;
    chk(collision == coll_prev, "R7", "collision", int'(collision), int'(coll_prev));
    if (q.size() == LAT) begin
      e = q.pop_front();
      chk(res_valid == e.v, "R5", "res_valid", int'(res_valid), int'(e.v));
      if (e.v) begin
        chk(res_src == e.src, "R6", "res_src", int'(res_src), int'(e.src));
        chk(int'(res_sum) == e.sum, "R3", "res_sum", int'(res_sum), e.sum);
        chk(res_pass == e.pass, "R4", "res_pass", int'(res_pass), int'(e.pass));
        chk(int'(res_coord) == e.coord, "R8", "res_coord", int'(res_coord), e.coord);
      end else begin
        chk(res_pass == 1'b0, "R10", "res_pass idle", int'(res_pass), 0);
      end
    end
  endtask

  function automatic int model_sum(input logic [63:0] codes);
    int s = 0;
    for (int f = 0; f < NF; f++) s += tbl[f][codes[f*8 +: 8]];
    return s;
  endfunction

  // one request cycle; expected values come from the bench tables (R2)
  task automatic step(input bit av, input logic [63:0] ac, input int acd,
                      input bit bv, input logic [63:0] bc, input int bcd);
    exp_t e;
    logic [63:0] codes;
    @(negedge clk);
    compare_outputs();
    cfg_tbl_we = 1'b0;
    cfg_thr_we = 1'b0;
    a_valid = av; a_codes = ac; a_coord = 16'(acd);
    b_valid = bv; b_codes = bc; b_coord = 16'(bcd);
    codes   = bv ? bc : ac;
    e.v     = av | bv;
    e.src   = bv;
    e.sum   = model_sum(codes);
    e.pass  = e.v && (e.sum > thr_m);
    e.coord = bv ? (bcd & 16'hFFFF) : (acd & 16'hFFFF);
    q.push_back(e);
    coll_prev = av & bv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 0, 1'b0, '0, 0);
  endtask

  // R9: table write, visible to requests from the next cycle on
  task automatic wr_tbl(input int f, input int a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    compare_outputs();
    a_valid = 1'b0; b_valid = 1'b0; cfg_thr_we = 1'b0;
    cfg_tbl_we = 1'b1; cfg_feat = 3'(f); cfg_addr = 8'(a); cfg_data = d;
    e.v = 1'b0; e.src = 1'b0; e.sum = 0; e.pass = 1'b0; e.coord = 0;
    q.push_back(e);
    coll_prev = 1'b0;
    tbl[f][a] = int'($signed(d));
  endtask

  // R9: threshold write after the pipeline has drained
  task automatic wr_thr(input int t);
    exp_t e;
    idle(LAT);
    @(negedge clk);
    compare_outputs();
    a_valid = 1'b0; b_valid = 1'b0; cfg_tbl_we = 1'b0;
    cfg_thr_we = 1'b1; cfg_thr = 11'(t);
    e.v = 1'b0; e.src = 1'b0; e.sum = 0; e.pass = 1'b0; e.coord = 0;
    q.push_back(e);
    coll_prev = 1'b0;
    thr_m = t;
  endtask

  // R1 R11: reset, then the pipeline must stay empty
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    a_valid = 1'b0; b_valid = 1'b0; cfg_tbl_we = 1'b0; cfg_thr_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete();
    coll_prev = 1'b0;
    thr_m = 0;
    for (int f = 0; f < NF; f++)
      for (int a = 0; a < 256; a++) tbl[f][a] = 0;
    chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
    chk(res_pass == 1'b0, "R1", "res_pass after reset", int'(res_pass), 0);
    chk(collision == 1'b0, "R1", "collision after reset", int'(collision), 0);
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R11", "no stale result", int'(res_valid), 0);
      chk(collision == 1'b0, "R11", "no stale collision", int'(collision), 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int s5;
    n_cmp = 0;
    n_bad = 0;
    finished = 1'b0;
    do_reset();

    // R1: cleared tables and zero threshold give sum 0, fail
    step(1'b1, {$urandom, $urandom}, 7, 1'b0, '0, 0);
    step(1'b0, '0, 0, 1'b1, {$urandom, $urandom}, 9);
    idle(LAT + 1);

    // R9 R2: load every table with pseudo-random confidences
    for (int f = 0; f < NF; f++)
      for (int a = 0; a < 256; a++) wr_tbl(f, a, 8'($urandom));
    wr_thr(0);

    // R2 R3 R5 R6 R7 R8 R10: mixed random traffic, gaps and collisions
    for (int i = 0; i < 400; i++) begin
      bit av = ($urandom % 4) != 0;
      bit bv = ($urandom % 3) == 0;
      step(av, {$urandom, $urandom}, 1000 + i, bv, {$urandom, $urandom}, 30000 + i);
    end
    idle(12);
    // R7: collision burst, B always served
    for (int i = 0; i < 5; i++)
      step(1'b1, {$urandom, $urandom}, i, 1'b1, {$urandom, $urandom}, 500 + i);
    idle(LAT);

    // R3: extreme sums
    for (int f = 0; f < NF; f++) begin
      wr_tbl(f, 255, 8'sd127);
      wr_tbl(f, 0, 8'h80);
    end
    step(1'b1, {8{8'hFF}}, 11, 1'b0, '0, 0);
    step(1'b0, '0, 0, 1'b1, {8{8'h00}}, 12);
    idle(LAT);

    // R4: threshold boundary, equal fails and one below passes
    s5 = model_sum({8{8'h05}});
    wr_thr(s5);
    step(1'b1, {8{8'h05}}, 21, 1'b0, '0, 0);
    wr_thr(s5 - 1);
    step(1'b1, {8{8'h05}}, 22, 1'b0, '0, 0);
    wr_thr(-1024);
    step(1'b0, '0, 0, 1'b1, {8{8'h00}}, 23);
    wr_thr(1016);
    step(1'b0, '0, 0, 1'b1, {8{8'hFF}}, 24);
    wr_thr(0);

    // R9: write then use the same entry on the next cycle
    wr_tbl(3, 9, 8'sd100);
    step(1'b1, {8{8'h09}}, 31, 1'b0, '0, 0);
    wr_tbl(3, 9, 8'hC0);
    step(1'b1, {8{8'h09}}, 32, 1'b0, '0, 0);
    idle(LAT);

    // R11: reset with requests in flight
    for (int i = 0; i < 4; i++)
      step(1'b1, {$urandom, $urandom}, 40 + i, 1'b0, '0, 0);
    do_reset();
    step(1'b1, {8{8'h09}}, 50, 1'b0, '0, 0);
    step(1'b0, '0, 0, 1'b1, {8{8'hFF}}, 51);
    idle(LAT + 2);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule